// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software progress with a 12-bit down counter that decrements once per pulse of a slow 256 Hz tick enable. Software must restart the counter before it reaches zero, and only inside a restart window. The window opens once the counter has fallen to or below a programmed delta value. If the counter underflows, or a restart arrives while the counter is still above the delta, the block records the fault. It can then raise an interrupt and request a reset of either the processor alone or the whole system.

Configuration sits in a mode register that accepts exactly one write after reset. That write fixes:
- the reload value,
- the window delta,
- whether a fault raises an interrupt or a reset, and which reset it requests,
- a disable bit,
- two halt options that freeze the counter while the debug or idle input is high.

Restart commands go to a control register and take effect only when they carry a key. A clear-on-read status register reports which fault occurred. The current counter value can be read back.

Top module: `wdt_window`

## Requirements
- R1: After reset, the mode register (address 1) reads 0x3FFF2FFF, status (address 2) reads 0, the counter (address 3) reads 0xFFF, and faultIrq, procRstReq and sysRstReq are low.
- R2: Only the first write to the mode register after reset takes effect, and every later write leaves it unchanged. Bits 31:30 of the mode register always read zero.
- R3: A write to the control register (address 0) is a restart only when bits 31:24 hold 0xA5 and bit 0 is set. A restart made while the counter is at or below the delta field (mode bits 27:16) reloads the counter from the reload field (mode bits 11:0). A control write with any other key changes nothing.
- R4: A keyed restart made while the counter is above the delta leaves the counter unchanged and sets status bit 1 (window error).
- R5: Each tick decrements the counter by one. A tick that arrives at zero reloads the counter from the reload field and sets status bit 0 (underflow).
- R6: Reading the status register returns its current value and clears it. A fault that occurs in the same cycle as the read stays set.
- R7: faultIrq is high exactly when status is nonzero and mode bit 12 (interrupt enable) is set.
- R8: When mode bit 13 (reset enable) is set, a fault produces a one-cycle reset request in the cycle after the fault. The request goes on procRstReq when mode bit 14 is set and on sysRstReq when it is clear, and the two are never high together.
- R9: While mode bit 15 (disable) is set, the counter holds its value, restarts have no effect, and no status bit or reset request is raised.
- R10: The counter ignores ticks while dbgIn is high and mode bit 28 is set, and while idleIn is high and mode bit 29 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick256 | input | 1 | One-cycle count enable at 256 Hz |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (clears status when reading address 2) |
| regAddr | input | 2 | Register select: 0 control, 1 mode, 2 status, 3 counter |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from address |
| dbgIn | input | 1 | Debug-halt request |
| idleIn | input | 1 | Idle-halt request |
| faultIrq | output | 1 | Fault interrupt level |
| procRstReq | output | 1 | Processor-only reset request pulse |
| sysRstReq | output | 1 | System reset request pulse |

## Verification
The bench goes after the window boundary. A restart at a count exactly equal to the delta must reload the counter, and one taken from above the delta must only flag an error. A design that compares with the wrong inequality would either reload early or fault on a legal restart.

It also covers these cases:
- A mode write after the first one must be ignored; a design that does not lock would take on the second configuration.
- A control write with the wrong key must change nothing; a design that only checks the restart bit would flag a window error.
- Disable must suppress all faults; a design that only gates the tick would still raise window errors.
- The halt options must freeze the counter; a design that misses them would keep counting.
- The reset request must be steered by the processor-only bit; a design that gets this wrong would request the wrong reset.
- Status must clear only when it is read; a design that gets this wrong would keep the interrupt level stuck high.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W  = 12;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int STAT_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd3;

  localparam logic [7:0]        RESTART_KEY = 8'hA5;
  localparam logic [DATA_W-1:0] MODE_RESET  = 32'h3FFF_2FFF;
  localparam logic [DATA_W-1:0] MODE_MASK   = 32'h3FFF_FFFF;

  localparam int RELOAD_LSB = 0;
  localparam int DELTA_LSB  = 16;
  localparam int BIT_INT_EN = 12;
  localparam int BIT_RST_EN = 13;
  localparam int BIT_PROC   = 14;
  localparam int BIT_DIS    = 15;
  localparam int BIT_DBG_H  = 28;
  localparam int BIT_IDLE_H = 29;

  localparam int ST_UNDER = 0;
  localparam int ST_EARLY = 1;

  typedef struct packed {
    logic reload;
    logic countEn;
  } wdStrobe_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        strobe,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [CNT_W-1:0] deltaVal,
  output logic [CNT_W-1:0] count,
  output logic             underflow,
  output logic             inWindow
);
  logic atZero;

  assign atZero    = (count == '0);
  assign underflow = strobe.countEn && !strobe.reload && atZero;
  assign inWindow  = (count <= deltaVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '1;
    end else if (strobe.reload) begin
      count <= reloadVal;
    end else if (strobe.countEn) begin
      count <= atZero ? reloadVal : count - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick256,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              dbgIn,
  input  logic              idleIn,
  input  logic [CNT_W-1:0]  count,
  input  logic              underflow,
  input  logic              inWindow,
  output wdStrobe_t         strobe,
  output logic [DATA_W-1:0] modeReg,
  output logic [STAT_W-1:0] statusReg,
  output logic [DATA_W-1:0] regRdData,
  output logic              faultIrq,
  output logic              procRstReq,
  output logic              sysRstReq
);
  logic modeLocked;
  logic keyedRestart;
  logic enabled;
  logic earlyErr;
  logic halted;
  logic fault;
  logic statusRead;
  logic [STAT_W-1:0] newEvents;

  assign keyedRestart = regWrEn && (regAddr == ADDR_CTRL)
                        && (regWrData[31:24] == RESTART_KEY) && regWrData[0];
  assign enabled   = !modeReg[BIT_DIS];
  assign halted    = (dbgIn && modeReg[BIT_DBG_H]) || (idleIn && modeReg[BIT_IDLE_H]);
  assign earlyErr  = keyedRestart && enabled && !inWindow;
  assign fault     = underflow || earlyErr;
  assign statusRead = regRdEn && (regAddr == ADDR_STAT);

  always_comb begin
    newEvents = '0;
    newEvents[ST_UNDER] = underflow;
    newEvents[ST_EARLY] = earlyErr;
  end

  assign strobe.reload  = keyedRestart && enabled && inWindow;
  assign strobe.countEn = tick256 && enabled && !halted;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg    <= MODE_RESET;
      modeLocked <= 1'b0;
    end else if (regWrEn && (regAddr == ADDR_MODE) && !modeLocked) begin
      modeReg    <= regWrData & MODE_MASK;
      modeLocked <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg  <= '0;
      procRstReq <= 1'b0;
      sysRstReq  <= 1'b0;
    end else begin
      statusReg  <= (statusRead ? '0 : statusReg) | newEvents;
      procRstReq <= fault && modeReg[BIT_RST_EN] && modeReg[BIT_PROC];
      sysRstReq  <= fault && modeReg[BIT_RST_EN] && !modeReg[BIT_PROC];
    end
  end

  assign faultIrq = modeReg[BIT_INT_EN] && (statusReg != '0);

  always_comb begin
    unique case (regAddr)
      ADDR_MODE: regRdData = modeReg;
      ADDR_STAT: regRdData = {{(DATA_W-STAT_W){1'b0}}, statusReg};
      ADDR_CNT:  regRdData = {{(DATA_W-CNT_W){1'b0}}, count};
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/wdt_window.sv
module wdt_window
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick256,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              dbgIn,
  input  logic              idleIn,
  output logic              faultIrq,
  output logic              procRstReq,
  output logic              sysRstReq
);
  wdStrobe_t         strobe;
  logic [DATA_W-1:0] modeReg;
  logic [STAT_W-1:0] statusReg;
  logic [CNT_W-1:0]  count;
  logic              underflow;
  logic              inWindow;

  wdt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick256(tick256),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .dbgIn(dbgIn), .idleIn(idleIn),
    .count(count), .underflow(underflow), .inWindow(inWindow),
    .strobe(strobe), .modeReg(modeReg), .statusReg(statusReg), .regRdData(regRdData),
    .faultIrq(faultIrq), .procRstReq(procRstReq), .sysRstReq(sysRstReq)
  );

  wdt_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reloadVal(modeReg[RELOAD_LSB +: CNT_W]),
    .deltaVal(modeReg[DELTA_LSB +: CNT_W]),
    .count(count), .underflow(underflow), .inWindow(inWindow)
  );
endmodule

// File: rtl/wdt_checks.sv
module wdt_checks
  import wdt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] modeReg,
  input logic [CNT_W-1:0]  count,
  input logic [STAT_W-1:0] statusReg,
  input logic              faultIrq,
  input logic              procRstReq,
  input logic              sysRstReq
);
  logic sawModeWr;

  always_ff @(posedge clk) begin
    if (!rstN) sawModeWr <= 1'b0;
    else if (regWrEn && regAddr == ADDR_MODE) sawModeWr <= 1'b1;
  end

  assert_mode_locked_R2: assert property (@(posedge clk) disable iff (!rstN)
    sawModeWr |=> $stable(modeReg));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |->
      (count == 12'($past(count) - 1'b1) || count == $past(modeReg[RELOAD_LSB +: CNT_W])));

  assert_irq_needs_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    faultIrq |-> (statusReg != '0));

  assert_rst_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(procRstReq && sysRstReq));

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    modeReg[BIT_DIS] |=> ($stable(count) && !procRstReq && !sysRstReq));
endmodule

bind wdt_window wdt_checks u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .modeReg(modeReg), .count(count), .statusReg(statusReg),
  .faultIrq(faultIrq), .procRstReq(procRstReq), .sysRstReq(sysRstReq)
);

// File: tb/wdt_window_test.sv
module wdt_window_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick256 = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        dbgIn = 1'b0;
  logic        idleIn = 1'b0;
  logic        faultIrq, procRstReq, sysRstReq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  wdt_window uut (
    .clk(clk), .rstN(rstN), .tick256(tick256),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .dbgIn(dbgIn), .idleIn(idleIn),
    .faultIrq(faultIrq), .procRstReq(procRstReq), .sysRstReq(sysRstReq)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_PIN = 2'd3;
  localparam logic [31:0] GO = 32'hA500_0001;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // Mode in force: reload 5, delta 3, irq on, reset on, processor-only, halts on.
  // Pin word is {faultIrq, procRstReq, sysRstReq}.
  localparam vec_t VEC [22] = '{
    '{OP_RD,  2'd3, 32'h0,          32'hFFF, 4'd5},  // R5 counter untouched so far
    '{OP_WR,  2'd0, 32'h5A00_0001,  32'h0,   4'd3},  // R3 wrong key
    '{OP_PIN, 2'd0, 32'h0,          32'h0,   4'd3},  // R3 no fault from it
    '{OP_RD,  2'd2, 32'h0,          32'h0,   4'd3},  // R3 status still clear
    '{OP_WR,  2'd0, GO,             32'h0,   4'd4},  // R4 restart above delta
    '{OP_PIN, 2'd0, 32'h0,          32'h6,   4'd8},  // R8 irq + processor reset pulse
    '{OP_RD,  2'd3, 32'h0,          32'hFFF, 4'd4},  // R4 no reload
    '{OP_RD,  2'd2, 32'h0,          32'h2,   4'd6},  // R6 window error, then clear
    '{OP_PIN, 2'd0, 32'h0,          32'h0,   4'd7},  // R7 irq drops after clear
    '{OP_RD,  2'd2, 32'h0,          32'h0,   4'd6},  // R6 cleared
    '{OP_TK,  2'd0, 32'd4095,       32'h0,   4'd5},  // R5 run down to zero
    '{OP_RD,  2'd3, 32'h0,          32'h0,   4'd5},  // R5 at zero
    '{OP_TK,  2'd0, 32'd1,          32'h0,   4'd5},  // R5 underflow tick
    '{OP_PIN, 2'd0, 32'h0,          32'h6,   4'd8},  // R8 pulse on underflow
    '{OP_RD,  2'd3, 32'h0,          32'h5,   4'd5},  // R5 reloaded
    '{OP_RD,  2'd2, 32'h0,          32'h1,   4'd5},  // R5 underflow bit
    '{OP_TK,  2'd0, 32'd2,          32'h0,   4'd5},  // R5 5 -> 3
    '{OP_RD,  2'd3, 32'h0,          32'h3,   4'd5},  // R5
    '{OP_WR,  2'd0, GO,             32'h0,   4'd3},  // R3 restart with count equal to delta
    '{OP_PIN, 2'd0, 32'h0,          32'h0,   4'd3},  // R3 legal, no fault
    '{OP_RD,  2'd3, 32'h0,          32'h5,   4'd3},  // R3 reloaded
    '{OP_RD,  2'd2, 32'h0,          32'h0,   4'd3}   // R3 no status
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); tick256 = 1'b1;
    @(negedge clk); tick256 = 1'b0;
  endtask

  function automatic logic [31:0] pins();
    return {29'b0, faultIrq, procRstReq, sysRstReq};
  endfunction

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    doReset();
    // R1 reset state
    rd(2'd1, d); check("R1 mode reset", d, 32'h3FFF_2FFF);
    rd(2'd2, d); check("R1 status reset", d, 32'h0);
    rd(2'd3, d); check("R1 counter reset", d, 32'hFFF);
    #1 check("R1 outputs low", pins(), 32'h0);

    // R2 write-once, top bits read zero
    wr(2'd1, 32'hF003_7005);
    rd(2'd1, d); check("R2 first write, bits 31:30 zero", d, 32'h3003_7005);
    wr(2'd1, 32'h0000_8FFF);
    rd(2'd1, d); check("R2 second write ignored", d, 32'h3003_7005);

    for (int i = 0; i < 22; i++) begin
      case (VEC[i].op)
        OP_WR: wr(VEC[i].addr, VEC[i].data);
        OP_TK: for (int k = 0; k < int'(VEC[i].data); k++) tick();
        OP_RD: begin
          rd(VEC[i].addr, d);
          check($sformatf("table step %0d R%0d", i, VEC[i].req), d, VEC[i].exp);
        end
        default: begin
          #1 check($sformatf("table step %0d pins R%0d", i, VEC[i].req), pins(), VEC[i].exp);
        end
      endcase
    end

    // R10 halt inputs freeze the counter (counter is 5 here)
    dbgIn = 1'b1; tick(); dbgIn = 1'b0;
    rd(2'd3, d); check("R10 debug halt", d, 32'h5);
    idleIn = 1'b1; tick(); idleIn = 1'b0;
    rd(2'd3, d); check("R10 idle halt", d, 32'h5);
    tick();
    rd(2'd3, d); check("R10 counting resumes", d, 32'h4);

    // Phase 2: system reset, interrupt disabled
    doReset();
    wr(2'd1, 32'h0002_2002);
    wr(2'd0, GO);
    #1 check("R8 system reset pulse, R7 irq gated", pins(), 32'h1);
    @(negedge clk);
    #1 check("R8 pulse lasts one cycle", pins(), 32'h0);
    rd(2'd2, d); check("R4 window error recorded", d, 32'h2);

    // Phase 3: disabled
    doReset();
    wr(2'd1, 32'h3002_A002);
    repeat (3) tick();
    rd(2'd3, d); check("R9 counter frozen", d, 32'hFFF);
    wr(2'd0, GO);
    #1 check("R9 no reset request", pins(), 32'h0);
    rd(2'd2, d); check("R9 no status", d, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule